// File: doc/BRIEF.md
# Macro-op Group ID Translation Table

This block sits between decode and the issue queue. It turns register dependences between single instructions into dependences between fused scheduling groups. Instructions come in program order, at most two per cycle. Each instruction carries a pairing offset, an optional destination register and two source registers.

Every instruction that opens a new group takes a group ID from a free pool. When an instruction's pairing offset is non-zero, the instruction that many positions later in program order joins the same group and reuses that ID. For each instruction the block reports its group ID, whether it is the second member of a pair, and for each source the group that produces it, if any. A group ID is returned to the pool through a release port. Any register still mapped to a released group then counts as having no pending producer.

Register values are still read through physical register numbers elsewhere. Only scheduling dependences go through this table. When the pool cannot cover the IDs a cycle needs, the input handshake stalls.

Top module: `mopXlatTable`

## Requirements
- R1: After reset, `outValid` is 0, every group ID 0..15 is free, and no logical register has a producer: a source read before any write reports `outDep`=0.
- R2: An instruction that is not a pair tail receives the lowest-numbered free ID. When both lanes need an ID in one cycle, lane 0 gets the lowest and lane 1 the next lowest.
- R3: A pairing offset p in 1..7 on an instruction that is not itself a tail makes the instruction p positions later in program order a tail. Positions count across cycles, lane 0 before lane 1. That tail receives the same ID with `outTail`=1. An offset of 0 means unpaired.
- R4: A source reports `outDep`=1 and `outDepGid` equal to the group ID of the most recent older instruction in program order that wrote that register.
- R5: A lane-1 source naming lane 0's destination in the same cycle resolves to lane 0's ID. When both lanes write one register, lane 1's ID is the one kept for later readers.
- R6: A source whose producer has the reader's own group ID, as when a tail reads its head's result, reports `outDep`=0.
- R7: Instructions placed between a head and its tail that read the head's destination see the shared group ID.
- R8: A tail's own pairing offset is ignored. A head whose target position is already claimed by an earlier head stays unpaired: it keeps its own ID and marks no tail.
- R9: `inReady` is 0 exactly when the new IDs the offered lanes need exceed the free count. No instruction is then taken and no state changes.
- R10: A release makes the ID free from the next cycle. Registers mapped to it report `outDep`=0 from then on, unless they are written again.
- R11: Results appear one cycle after a transfer, with `outValid[l]` set only for transferred lanes. `inValid`=2'b10 transfers nothing.
- R12: An instruction with `inDstValid`=0 leaves the register mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 2 | Lane valid; lane 1 only counts with lane 0 |
| inPtr | input | 2x3 | Pairing offset per lane, 0 = none |
| inDstValid | input | 2 | Lane writes a destination register |
| inDst | input | 2x3 | Destination logical register |
| inSrc | input | 2x2x3 | Two source logical registers per lane |
| inReady | output | 1 | Offered lanes can be accepted this cycle |
| relValid | input | 1 | Return a group ID to the pool |
| relId | input | 4 | Group ID being returned |
| outValid | output | 2 | Lane result valid |
| outGid | output | 2x4 | Group ID of the instruction |
| outTail | output | 2 | Instruction is the second member of a pair |
| outDep | output | 2x2 | Source has an outstanding producing group |
| outDepGid | output | 2x2x4 | Producing group ID per source |

## Verification
The hardest condition to reach is the pool edge, where a single free ID remains while two non-tail lanes are offered, alongside a lane-1 tail created by a lane-0 head in the same cycle, which needs only one ID. The bench holds back releases until the pool drains, offers pairs and singles at that edge, and then frees IDs one at a time. Claimed-target collisions and tails that carry their own offsets come from directed offset patterns. A long random phase then mixes offsets, bypasses and releases against an in-order reference model in the bench.

// File: rtl/mopXlatPkg.sv
package mopXlatPkg;
  // Lane logic is written for two lanes per cycle.
  localparam int LANES     = 2;
  localparam int NUM_IDS   = 16;
  localparam int ID_W      = $clog2(NUM_IDS);
  localparam int NUM_LREGS = 8;
  localparam int REG_W     = $clog2(NUM_LREGS);
  localparam int MAX_OFF   = 7;
  localparam int OFF_W     = $clog2(MAX_OFF + 1);
  localparam int PEND_N    = LANES + MAX_OFF;
  localparam int CNT_W     = $clog2(NUM_IDS + 1);

  typedef struct packed {
    logic                        accept;
    logic [LANES-1:0]            fire;
    logic [LANES-1:0]            isTail;
    logic [LANES-1:0][ID_W-1:0]  gid;
  } xlatStrobe_t;
endpackage

// File: rtl/mopXlatCtrl.sv
module mopXlatCtrl import mopXlatPkg::*; (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0][OFF_W-1:0] inPtr,
  input  logic                        relValid,
  input  logic [ID_W-1:0]             relId,
  output logic                        inReady,
  output xlatStrobe_t                 strobe
);
  logic [NUM_IDS-1:0]           freeVec, nxtFree;
  logic [PEND_N-1:0]            pendV, nxtPendV;
  logic [PEND_N-1:0][ID_W-1:0]  pendId, nxtPendId;
  logic [ID_W-1:0]              first, second, gid0, gid1;
  logic                         gotFirst, gotSecond;
  logic [CNT_W-1:0]             freeCount;
  logic                         v0, v1, tail0, tail1, head0, head1, pairIn;
  logic                         need0, need1, accept;
  logic [1:0]                   needCnt;
  logic [OFF_W:0]               tgt1;
  int                           shiftN;

  // lowest and second-lowest free ID
  always_comb begin
    first = '0; second = '0; gotFirst = 1'b0; gotSecond = 1'b0;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (freeVec[i]) begin
        if (!gotFirst) begin
          first = ID_W'(i); gotFirst = 1'b1;
        end else if (!gotSecond) begin
          second = ID_W'(i); gotSecond = 1'b1;
        end
      end
    end
  end

  assign freeCount = CNT_W'($countones(freeVec));

  // pairing decisions for the two lanes
  always_comb begin
    v0     = inValid[0];
    v1     = inValid[0] & inValid[1];
    tail0  = pendV[0];
    head0  = v0 && !tail0 && (inPtr[0] != '0) && !pendV[inPtr[0]];
    pairIn = head0 && (inPtr[0] == OFF_W'(1));
    tail1  = pendV[1] || pairIn;
    tgt1   = {1'b0, inPtr[1]} + 1'b1;
    head1  = v1 && !tail1 && (inPtr[1] != '0) && !pendV[tgt1]
             && !(head0 && ({1'b0, inPtr[0]} == tgt1));
    need0  = v0 && !tail0;
    need1  = v1 && !tail1;
    needCnt = {1'b0, need0} + {1'b0, need1};
    inReady = CNT_W'(needCnt) <= freeCount;
    accept  = v0 && inReady;
    gid0    = tail0 ? pendId[0] : first;
    gid1    = pendV[1] ? pendId[1] : (pairIn ? gid0 : (need0 ? second : first));
  end

  // pending-tail window shifts by the number of instructions taken
  always_comb begin
    shiftN = v1 ? 2 : 1;
    for (int k = 0; k < PEND_N; k++) begin
      nxtPendV[k]  = 1'b0;
      nxtPendId[k] = '0;
      if (k + shiftN < PEND_N) begin
        nxtPendV[k]  = pendV[k + shiftN];
        nxtPendId[k] = pendId[k + shiftN];
      end
      if (head0 && (int'(inPtr[0]) - shiftN == k)) begin
        nxtPendV[k] = 1'b1; nxtPendId[k] = gid0;
      end
      if (head1 && (int'(tgt1) - shiftN == k)) begin
        nxtPendV[k] = 1'b1; nxtPendId[k] = gid1;
      end
    end
  end

  always_comb begin
    nxtFree = freeVec;
    if (accept && need0) nxtFree[first] = 1'b0;
    if (accept && need1) nxtFree[need0 ? second : first] = 1'b0;
    if (relValid) nxtFree[relId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeVec <= '1;
      pendV   <= '0;
      pendId  <= '0;
    end else begin
      freeVec <= nxtFree;
      if (accept) begin
        pendV  <= nxtPendV;
        pendId <= nxtPendId;
      end
    end
  end

  assign strobe.accept = accept;
  assign strobe.fire   = {accept & v1, accept};
  assign strobe.isTail = {tail1, tail0};
  assign strobe.gid    = {gid1, gid0};

  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (freeCount == '0 && inValid[0] && !pendV[0]) |-> !inReady); // R9
  AST_FREE_ACCOUNT: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !relValid) |=> (freeCount == $past(freeCount) - CNT_W'($past(needCnt)))); // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> (pendV == $past(pendV))); // R9
  AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    relValid |=> freeVec[$past(relId)]); // R10
endmodule

// File: rtl/mopXlatData.sv
module mopXlatData import mopXlatPkg::*; (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  xlatStrobe_t                            strobe,
  input  logic [LANES-1:0]                       inDstValid,
  input  logic [LANES-1:0][REG_W-1:0]            inDst,
  input  logic [LANES-1:0][1:0][REG_W-1:0]       inSrc,
  input  logic                                   relValid,
  input  logic [ID_W-1:0]                        relId,
  output logic [LANES-1:0]                       outValid,
  output logic [LANES-1:0][ID_W-1:0]             outGid,
  output logic [LANES-1:0]                       outTail,
  output logic [LANES-1:0][1:0]                  outDep,
  output logic [LANES-1:0][1:0][ID_W-1:0]        outDepGid
);
  logic [NUM_LREGS-1:0]            tabV;
  logic [NUM_LREGS-1:0][ID_W-1:0]  tabId;
  logic [LANES-1:0][1:0]           dep;
  logic [LANES-1:0][1:0][ID_W-1:0] depId;
  logic [1:0]                      byp;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      dep[0][k]   = tabV[inSrc[0][k]] && (tabId[inSrc[0][k]] != strobe.gid[0]);
      depId[0][k] = tabId[inSrc[0][k]];
      byp[k]      = inDstValid[0] && (inDst[0] == inSrc[1][k]);
      if (byp[k]) begin
        dep[1][k]   = strobe.gid[0] != strobe.gid[1];
        depId[1][k] = strobe.gid[0];
      end else begin
        dep[1][k]   = tabV[inSrc[1][k]] && (tabId[inSrc[1][k]] != strobe.gid[1]);
        depId[1][k] = tabId[inSrc[1][k]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tabV  <= '0;
      tabId <= '0;
    end else begin
      for (int r = 0; r < NUM_LREGS; r++) begin
        if (relValid && tabV[r] && (tabId[r] == relId)) tabV[r] <= 1'b0;
      end
      for (int l = 0; l < LANES; l++) begin
        if (strobe.fire[l] && inDstValid[l]) begin
          tabV[inDst[l]]  <= 1'b1;
          tabId[inDst[l]] <= strobe.gid[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= '0;
      outGid    <= '0;
      outTail   <= '0;
      outDep    <= '0;
      outDepGid <= '0;
    end else begin
      outValid  <= strobe.fire;
      outGid    <= strobe.gid;
      outTail   <= strobe.isTail & strobe.fire;
      outDep    <= dep;
      outDepGid <= depId;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : gLane
    for (genvar k = 0; k < 2; k++) begin : gSrc
      AST_NO_SELF_DEP: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[l] && outDep[l][k]) |-> (outDepGid[l][k] != outGid[l])); // R6
    end
  end
  AST_DISTINCT_ID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid[1] && !outTail[1]) |-> (outGid[1] != outGid[0])); // R2
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |=> (outValid == '0)); // R11
endmodule

// File: rtl/mopXlatTable.sv
module mopXlatTable import mopXlatPkg::*; (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [LANES-1:0]                   inValid,
  input  logic [LANES-1:0][OFF_W-1:0]        inPtr,
  input  logic [LANES-1:0]                   inDstValid,
  input  logic [LANES-1:0][REG_W-1:0]        inDst,
  input  logic [LANES-1:0][1:0][REG_W-1:0]   inSrc,
  output logic                               inReady,
  input  logic                               relValid,
  input  logic [ID_W-1:0]                    relId,
  output logic [LANES-1:0]                   outValid,
  output logic [LANES-1:0][ID_W-1:0]         outGid,
  output logic [LANES-1:0]                   outTail,
  output logic [LANES-1:0][1:0]              outDep,
  output logic [LANES-1:0][1:0][ID_W-1:0]    outDepGid
);
  xlatStrobe_t strobe;

  mopXlatCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPtr(inPtr),
    .relValid(relValid), .relId(relId), .inReady(inReady), .strobe(strobe)
  );

  mopXlatData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inDstValid(inDstValid),
    .inDst(inDst), .inSrc(inSrc), .relValid(relValid), .relId(relId),
    .outValid(outValid), .outGid(outGid), .outTail(outTail),
    .outDep(outDep), .outDepGid(outDepGid)
  );
endmodule

// File: tb/mopXlatTable_test.sv
module mopXlatTable_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]            sV = '0;
  logic [1:0][2:0]       sPtr = '0;
  logic [1:0]            sDv = '0;
  logic [1:0][2:0]       sDst = '0;
  logic [1:0][1:0][2:0]  sSrc = '0;
  logic                  sRv = 1'b0;
  logic [3:0]            sRid = '0;
  logic                  inReady;
  logic [1:0]            outValid, outTail;
  logic [1:0][3:0]       outGid;
  logic [1:0][1:0]       outDep;
  logic [1:0][1:0][3:0]  outDepGid;

  always #4 clk = ~clk;

  mopXlatTable uut (
    .clk(clk), .rstN(rstN), .inValid(sV), .inPtr(sPtr), .inDstValid(sDv),
    .inDst(sDst), .inSrc(sSrc), .inReady(inReady), .relValid(sRv), .relId(sRid),
    .outValid(outValid), .outGid(outGid), .outTail(outTail),
    .outDep(outDep), .outDepGid(outDepGid)
  );

  int nChk = 0, nFail = 0, mSeq = 0;
  logic [15:0] mFree, mHeld;
  logic [7:0] mTabV;
  logic [7:0][3:0] mTabId;
  logic [255:0] mPendV;
  logic [3:0] mPendId [256];
  logic [1:0] eValid = '0, eTail;
  logic [1:0][3:0] eGid;
  logic [1:0][1:0] eDep, eByp, eSelf;
  logic [1:0][1:0][3:0] eDepGid;
  string eTag = "";

  task automatic chk(string req, int act, int exp, string what);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string lab(string d);
    return (eTag == "") ? d : eTag;
  endfunction

  function automatic int freeCnt();
    int c = 0;
    for (int i = 0; i < 16; i++) c += mFree[i];
    return c;
  endfunction

  task automatic mLane(int l);
    int s = mSeq & 255;
    logic t = mPendV[s];
    logic [3:0] g = '0;
    logic found = 1'b0;
    if (t) begin
      g = mPendId[s]; mPendV[s] = 1'b0; mHeld[g] = 1'b0;
    end else begin
      for (int i = 0; i < 16; i++)
        if (!found && mFree[i]) begin g = 4'(i); found = 1'b1; end
      mFree[g] = 1'b0;
    end
    for (int k = 0; k < 2; k++) begin
      eDep[l][k]    = mTabV[sSrc[l][k]] && (mTabId[sSrc[l][k]] != g);
      eDepGid[l][k] = mTabId[sSrc[l][k]];
      eSelf[l][k]   = mTabV[sSrc[l][k]] && (mTabId[sSrc[l][k]] == g);
      eByp[l][k]    = (l == 1) && sDv[0] && (sDst[0] == sSrc[1][k]);
    end
    if (!t && sPtr[l] != 0 && !mPendV[(s + int'(sPtr[l])) & 255]) begin
      mPendV[(s + int'(sPtr[l])) & 255] = 1'b1;
      mPendId[(s + int'(sPtr[l])) & 255] = g;
      mHeld[g] = 1'b1;
    end
    if (sDv[l]) begin mTabV[sDst[l]] = 1'b1; mTabId[sDst[l]] = g; end
    eGid[l] = g; eTail[l] = t;
    mSeq++;
  endtask

  task automatic compareOut();
    chk(lab("R11"), outValid, eValid, "outValid");
    for (int l = 0; l < 2; l++) if (eValid[l]) begin
      chk(lab(eTail[l] ? "R3" : "R2"), outGid[l], eGid[l], "outGid");
      chk(lab("R3"), outTail[l], eTail[l], "outTail");
      for (int k = 0; k < 2; k++) begin
        chk(lab(eSelf[l][k] ? "R6" : (eByp[l][k] ? "R5" : "R4")), outDep[l][k], eDep[l][k], "outDep");
        if (eDep[l][k])
          chk(lab(eByp[l][k] ? "R5" : "R4"), outDepGid[l][k], eDepGid[l][k], "outDepGid");
      end
    end
  endtask

  // called at a falling edge with staging already set
  task automatic cyc(string tag);
    int s = mSeq & 255;
    logic t0, t1, v1, expReady;
    int need;
    compareOut();
    #1;
    t0 = mPendV[s];
    t1 = mPendV[(s + 1) & 255] ||
         (!t0 && sPtr[0] == 1 && !mPendV[(s + 1) & 255]);
    v1 = sV[0] & sV[1];
    need = int'(sV[0] & !t0) + int'(v1 & !t1);
    expReady = need <= freeCnt();
    chk((tag == "") ? "R9" : tag, inReady, expReady, "inReady");
    eTag = tag;
    eValid = '0;
    if (sV[0] && expReady) begin
      mLane(0); eValid[0] = 1'b1;
      if (v1) begin mLane(1); eValid[1] = 1'b1; end
    end
    if (sRv) begin
      mFree[sRid] = 1'b1;
      for (int r = 0; r < 8; r++)
        if (mTabV[r] && mTabId[r] == sRid) mTabV[r] = 1'b0;
    end
    @(negedge clk);
    sRv = 1'b0;
  endtask

  task automatic put(int lane, int ptr, int dv, int dst, int a, int b);
    sPtr[lane] = 3'(ptr); sDv[lane] = dv[0]; sDst[lane] = 3'(dst);
    sSrc[lane][0] = 3'(a); sSrc[lane][1] = 3'(b);
  endtask

  function automatic int pickRel(int start);
    for (int i = 0; i < 16; i++) begin
      int j = (start + i) & 15;
      if (!mFree[j] && !mHeld[j]) return j;
    end
    return -1;
  endfunction

  task automatic relOne(int start);
    int j = pickRel(start);
    if (j >= 0) begin sRv = 1'b1; sRid = 4'(j); end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    mFree = '1; mHeld = '0; mTabV = '0; mTabId = '0; mPendV = '0;
    for (int i = 0; i < 256; i++) mPendId[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1", outValid, 0, "outValid after reset");
    sV = 2'b01; put(0, 0, 1, 1, 3, 4); cyc("R1");
    // R3 and R6: pair inside one cycle, tail reads head result
    sV = 2'b11; put(0, 1, 1, 1, 2, 3); put(1, 0, 1, 5, 1, 4); cyc("R6");
    // R5: bypass and same destination on both lanes
    sV = 2'b11; put(0, 0, 1, 2, 0, 0); put(1, 0, 1, 2, 2, 1); cyc("R5");
    sV = 2'b01; put(0, 0, 0, 0, 2, 5); cyc("R5");
    // R7: head with offset 5, readers in between
    sV = 2'b01; put(0, 5, 1, 7, 0, 0); cyc("R3");
    for (int i = 0; i < 4; i++) begin put(0, 0, 1, 6, 7, 6); cyc("R7"); end
    put(0, 0, 1, 4, 7, 6); cyc("R3");
    // R8: claimed target and a tail carrying its own offset
    put(0, 2, 1, 3, 0, 0); cyc("R8");
    put(0, 1, 1, 4, 3, 0); cyc("R8");
    put(0, 3, 1, 5, 3, 4); cyc("R8");
    for (int i = 0; i < 3; i++) begin put(0, 0, 0, 0, 5, 3); cyc("R8"); end
    // R12: no destination leaves the mapping alone
    put(0, 0, 0, 5, 0, 0); cyc("R12");
    put(0, 0, 0, 0, 5, 5); cyc("R12");
    // R11: lane 1 alone is ignored; then idle
    sV = 2'b10; put(1, 0, 1, 6, 6, 6); cyc("R11");
    sV = 2'b00; cyc("R11");
    // R10: release and observe the mapped register
    relOne(0); sV = 2'b00; cyc("R10");
    sV = 2'b11; put(0, 0, 1, 0, 3, 5); put(1, 0, 1, 1, 2, 4); cyc("R10");
    // R9: drain the pool without releases
    for (int i = 0; i < 12; i++) begin
      sV = 2'b11; put(0, 0, 1, i & 7, (i + 1) & 7, 2); put(1, 0, 1, (i + 3) & 7, i & 7, 5);
      cyc("R9");
    end
    relOne(3); sV = 2'b00; cyc("R9");
    sV = 2'b11; put(0, 0, 1, 1, 1, 2); put(1, 0, 1, 2, 1, 3); cyc("R9");
    sV = 2'b11; put(0, 1, 1, 1, 1, 2); put(1, 0, 1, 2, 1, 3); cyc("R9");
    sV = 2'b01; put(0, 0, 1, 1, 2, 2); cyc("R9");
    // random mix
    for (int c = 0; c < 3000; c++) begin
      for (int l = 0; l < 2; l++) begin
        int r = int'($urandom);
        put(l, (r & 1) ? ((r >> 1) & 7) : 0, ((r >> 4) & 3) != 0, (r >> 6) & 7,
            (r >> 9) & 7, (r >> 12) & 7);
      end
      sV = 2'(($urandom % 7 == 0) ? ($urandom & 3) : 3);
      if (freeCnt() < 6 || ($urandom % 10) < 3) relOne(int'($urandom & 15));
      cyc("");
    end
    sV = 2'b00; cyc("");
    compareOut();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule